// File: doc/BRIEF.md
# Asynchronous static RAM access sequencer

This block sits between a synchronous request port and a byte-wide asynchronous static RAM of 32768 locations. It accepts one read or one write at a time through a valid/ready handshake. It then drives the chip-select, output-enable, write-strobe, address and data lines of the memory so that every edge lands at least the required number of nanoseconds after the edge before it. Read data comes back on `rd_data` together with a one-cycle `done` pulse. A write also ends with a `done` pulse.

Each minimum time is a nanosecond parameter. The clock period is a parameter as well. At elaboration the block converts each time into a cycle count: it divides by the period, rounds up, and uses at least one cycle. Every access is split into phases, and a single down-counter sets the length of each phase.

A write is the overlap of chip-select low and write-strobe low. Output-enable stays high for the whole write. The data drivers turn on only after output-enable has been high for at least one cycle, so the memory and the controller never drive the data lines at the same time. The data lines are split into an input, an output and a driver-enable, so an external pad or tri-state buffer can join them.

Top module: `sram_ctl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` and `done` are 0, and `req_ready` is 1. A write that reset cuts off before its strobe phase leaves the memory unchanged.
- R2: A read holds `sram_ce_n` and `sram_oe_n` at 0 and `sram_we_n` at 1 for N_RD cycles. N_RD is the largest of the rounded-up read cycle, address access, select access and output-enable access times. With the defaults (20 ns clock) N_RD is 4. `sram_dq_in` is captured into `rd_data` on the edge that closes the last of those cycles.
- R3: During a write, `sram_we_n` is 0 while `sram_ce_n` is 0 for N_WP cycles. N_WP is the largest of the rounded-up strobe width and data setup time, and of the address-to-end and select-to-end times minus the setup phase. With the defaults N_WP is 3. The byte stored is the value of `sram_dq_out` when `sram_we_n` rises.
- R4: `sram_oe_n` stays 1 through every write phase. `sram_dq_oe` is 1 only in the strobe and recovery phases. It is never 1 while `sram_oe_n` is 0, and it rises only when `sram_oe_n` was already 1 in the cycle before.
- R5: A write begins with a setup phase of N_SU = max(1, ceil(address setup)) cycles: select low, strobe high, drivers off. It ends with a recovery phase of N_RC = max(1, ceil(write cycle) − N_SU − N_WP) cycles: select and strobe high, address and data still driven. With the defaults the whole write takes 5 cycles.
- R6: `req_ready` is 1 only when no access is running. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and its address, data and write flag are latched on that edge. Changing the request inputs after that edge does not alter `sram_addr` or the stored byte.
- R7: `done` is high for exactly one cycle. It rises on the edge that ends the access: N_RD edges after acceptance for a read, N_SU+N_WP+N_RC edges for a write. `rd_data` keeps its value until the next read completes.
- R8: `sram_ce_n` is high for at least one cycle between any two accesses. A request already waiting when `done` rises is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Controller is idle and will accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle pulse at the end of an access |
| rd_data | output | 8 | Byte returned by the last read |
| sram_addr | output | 15 | Address lines to the memory |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable of the memory, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_oe | output | 1 | Enable for the controller's data drivers |
| sram_dq_in | input | 8 | Data from the memory |

## Verification
The end of one access and the arrival of the next request can fall in the same cycle. The bench provokes this by raising `req_valid` with a write while a read is still running and holding it there. The check then has several parts:
- `req_ready` stays low and `sram_addr` keeps the read address until `done` pulses.
- The read byte is correct.
- `sram_ce_n` is high in the `done` cycle.
- The waiting write is accepted on the following edge and later reads back correctly.

A behavioural memory model judges every strobe against the nanosecond minimums. It returns a poison byte whenever a read samples data before the access times have passed.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WSU,
      ST_WPL,
      ST_WRC
   } st_e;

   // nanoseconds to whole cycles, rounded up, never below one
   function automatic int ns2cyc(input int t_ns, input int per_ns);
      int c;
      c = (t_ns + per_ns - 1) / per_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_cnt.sv
`timescale 1ns/1ps
module sram_ctl_cnt #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (load)       cnt_q <= load_val;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R7: a freshly loaded nonzero count is not already expired
   a_r7_cnt_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !zero);
endmodule

// File: rtl/sram_ctl_dpath.sv
`timescale 1ns/1ps
module sram_ctl_dpath #(
   parameter int AW = 15,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take_req,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          take_rd,
   input  logic [DW-1:0] dq_in,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] wdata_q,
   output logic [DW-1:0] rd_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (take_req) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rd_q <= '0;
      else if (take_rd) rd_q <= dq_in;
   end

   // R6: latched request fields only move on acceptance
   a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !take_req |=> ($stable(addr_q) && $stable(wdata_q)));
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int AW            = 15,
   parameter int DW            = 8,
   parameter int CLK_PERIOD_NS = 20,
   parameter int T_RC_NS       = 70,
   parameter int T_AA_NS       = 70,
   parameter int T_ACE_NS      = 70,
   parameter int T_DOE_NS      = 35,
   parameter int T_WC_NS       = 70,
   parameter int T_SCE_NS      = 60,
   parameter int T_AW_NS       = 60,
   parameter int T_SA_NS       = 0,
   parameter int T_PWE_NS      = 50,
   parameter int T_SD_NS       = 30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          done,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] sram_addr,
   output logic          sram_ce_n,
   output logic          sram_oe_n,
   output logic          sram_we_n,
   output logic [DW-1:0] sram_dq_out,
   output logic          sram_dq_oe,
   input  logic [DW-1:0] sram_dq_in
);
   localparam int P     = CLK_PERIOD_NS;
   localparam int N_RD  = imax(imax(ns2cyc(T_RC_NS, P), ns2cyc(T_AA_NS, P)),
                               imax(ns2cyc(T_ACE_NS, P), ns2cyc(T_DOE_NS, P)));
   localparam int N_SU  = ns2cyc(T_SA_NS, P);
   localparam int N_WP  = imax(imax(ns2cyc(T_PWE_NS, P), ns2cyc(T_SD_NS, P)),
                               imax(ns2cyc(T_AW_NS, P) - N_SU, ns2cyc(T_SCE_NS, P) - N_SU));
   localparam int N_RC  = imax(1, ns2cyc(T_WC_NS, P) - N_SU - N_WP);
   localparam int N_MAX = imax(imax(N_RD, N_SU), imax(N_WP, N_RC));
   localparam int CW    = $clog2(N_MAX + 1);

   generate
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("sram_ctl: CLK_PERIOD_NS must be positive");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("sram_ctl: AW and DW must be positive");
      end
   endgenerate

   st_e           st_q, st_d;
   logic          ld, zero, take_req, take_rd, done_q;
   logic [CW-1:0] ld_val;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q, rd_q;

   always_comb begin
      st_d     = st_q;
      ld       = 1'b0;
      ld_val   = '0;
      take_req = 1'b0;
      unique case (st_q)
         ST_IDLE: if (req_valid) begin
            take_req = 1'b1;
            ld       = 1'b1;
            if (req_write) begin
               st_d   = ST_WSU;
               ld_val = CW'(N_SU - 1);
            end else begin
               st_d   = ST_RD;
               ld_val = CW'(N_RD - 1);
            end
         end
         ST_RD:  if (zero) st_d = ST_IDLE;
         ST_WSU: if (zero) begin
            st_d   = ST_WPL;
            ld     = 1'b1;
            ld_val = CW'(N_WP - 1);
         end
         ST_WPL: if (zero) begin
            st_d   = ST_WRC;
            ld     = 1'b1;
            ld_val = CW'(N_RC - 1);
         end
         ST_WRC: if (zero) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   assign take_rd = (st_q == ST_RD) && zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= zero && (st_q == ST_RD || st_q == ST_WRC);
      end
   end

   sram_ctl_cnt #(.W(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .zero     (zero)
   );

   sram_ctl_dpath #(.AW(AW), .DW(DW)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_req  (take_req),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .take_rd   (take_rd),
      .dq_in     (sram_dq_in),
      .addr_q    (addr_q),
      .wdata_q   (wdata_q),
      .rd_q      (rd_q)
   );

   assign req_ready   = (st_q == ST_IDLE);
   assign sram_ce_n   = !(st_q == ST_RD || st_q == ST_WSU || st_q == ST_WPL);
   assign sram_oe_n   = (st_q != ST_RD);
   assign sram_we_n   = (st_q != ST_WPL);
   assign sram_dq_oe  = (st_q == ST_WPL || st_q == ST_WRC);
   assign sram_addr   = addr_q;
   assign sram_dq_out = wdata_q;
   assign done        = done_q;
   assign rd_data     = rd_q;

   a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> sram_oe_n);
   a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_dq_oe) |-> $past(sram_oe_n));
   a_r2_we_high_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> sram_we_n);
   a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
   a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_dq_out));
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r6_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   a_r8_gap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> sram_ce_n);
endmodule

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;
   localparam int PER = 20;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [14:0] req_addr;
   logic [7:0]  req_wdata;
   logic        req_ready, done;
   logic [7:0]  rd_data;
   logic [14:0] sram_addr;
   logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [7:0]  sram_dq_out;
   logic [7:0]  sram_dq_in = 8'hEE;

   int checks   = 0;
   int failures = 0;

   always #(PER/2) clk = ~clk;

   sram_ctl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .done(done), .rd_data(rd_data), .sram_addr(sram_addr),
      .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
      .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
   );

   // expected cycle counts, derived from the requirements
   function automatic int cy(input int t);
      int c;
      c = (t + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
   localparam int E_SU = cy(0);
   localparam int E_WP = mx(mx(cy(50), cy(30)), mx(cy(60) - E_SU, cy(60) - E_SU));
   localparam int E_RC = mx(1, cy(70) - E_SU - E_WP);
   localparam int L_RD = mx(mx(cy(70), cy(70)), mx(cy(70), cy(35)));
   localparam int L_WR = E_SU + E_WP + E_RC;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_min(input string req, input string what, input real act, input real lim);
      checks++;
      if (act < lim) begin
         failures++;
         $display("FAIL %s %s actual=%0.1f expected>=%0.1f", req, what, act, lim);
      end
   endtask

   // behavioural memory and reference contents
   logic [7:0] mem  [int unsigned];
   logic [7:0] refm [int unsigned];

   function automatic logic [7:0] ref_get(input logic [14:0] a);
      return refm.exists(int'(a)) ? refm[int'(a)] : 8'h00;
   endfunction
   function automatic logic [7:0] mem_get(input logic [14:0] a);
      return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
   endfunction

   realtime t_ce_f = 0, t_oe_f = 0, t_adr = 0, t_we_f = 0, t_dat = 0;
   bit      wr_armed = 1'b0;
   logic    p_ce_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
   logic [14:0] p_addr = '0;

   always @(sram_addr)         t_adr  = $realtime;
   always @(negedge sram_ce_n) t_ce_f = $realtime;
   always @(negedge sram_oe_n) t_oe_f = $realtime;
   always @(sram_dq_out)       t_dat  = $realtime;
   always @(posedge sram_dq_oe) t_dat = $realtime;
   always @(negedge sram_we_n) begin
      t_we_f   = $realtime;
      wr_armed = 1'b1;
   end

   always @(posedge sram_we_n) begin
      if (wr_armed) begin
         wr_armed = 1'b0;
         chk_min("R3", "strobe width ns", $realtime - t_we_f, 50.0);
         chk_min("R3", "data setup ns", $realtime - t_dat, 30.0);
         chk_min("R3", "address to write end ns", $realtime - t_adr, 60.0);
         chk_min("R3", "select to write end ns", $realtime - t_ce_f, 60.0);
         mem[int'(sram_addr)] = sram_dq_out;
      end
   end

   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (sram_dq_oe && !sram_oe_n) begin
            checks++; failures++;
            $display("FAIL R4 drivers on with oe_n low actual=1 expected=0");
         end
         if (sram_dq_oe && !p_dq_oe && !p_oe_n) begin
            checks++; failures++;
            $display("FAIL R4 no turnaround gap actual=0 expected=1");
         end
         if (!sram_oe_n && !sram_we_n) begin
            checks++; failures++;
            $display("FAIL R2 strobe low during read actual=0 expected=1");
         end
         if (!sram_ce_n && !p_ce_n && sram_addr != p_addr) begin
            checks++; failures++;
            $display("FAIL R6 address moved while selected actual=%0h expected=%0h",
                     sram_addr, p_addr);
         end
      end
      if (!sram_ce_n && !sram_oe_n && ($realtime - t_ce_f) >= 70.0 &&
          ($realtime - t_oe_f) >= 35.0 && ($realtime - t_adr) >= 70.0)
         sram_dq_in = mem_get(sram_addr);
      else
         sram_dq_in = 8'hEE;
      p_ce_n  = sram_ce_n;
      p_oe_n  = sram_oe_n;
      p_dq_oe = sram_dq_oe;
      p_addr  = sram_addr;
   end

   // watchdog
   bit finished = 1'b0;
   initial begin
      #(PER * 150000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog run did not end actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // present a request and hold it until taken, then scramble the inputs
   task automatic issue(input logic w, input logic [14:0] a, input logic [7:0] d);
      @(negedge clk);
      req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1;
      req_valid = 1'b0; req_write = ~w; req_addr = ~a; req_wdata = ~d;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (n == 1) chk("R6", "ready while busy", req_ready, 0);
      end while (!done && n < 40);
   endtask

   task automatic run(input logic w, input logic [14:0] a, input logic [7:0] d);
      int n;
      issue(w, a, d);
      wait_done(n);
      if (w) begin
         chk("R5", "write done latency", n, L_WR + 1);
         refm[int'(a)] = d;
      end else begin
         chk("R7", "read done latency", n, L_RD + 1);
         chk("R2", "read data", rd_data, ref_get(a));
      end
      chk("R8", "select high in done cycle", sram_ce_n, 1);
      @(negedge clk);
      chk("R7", "done single pulse", done, 0);
   endtask

   // {write, address, data}
   localparam int NV = 13;
   localparam logic [23:0] VEC [NV] = '{
      {1'b1, 15'h0000, 8'hA5}, {1'b1, 15'h7FFF, 8'h5A}, {1'b1, 15'h1234, 8'h3C},
      {1'b0, 15'h0000, 8'h00}, {1'b0, 15'h7FFF, 8'h00}, {1'b0, 15'h1234, 8'h00},
      {1'b1, 15'h1234, 8'hC3}, {1'b0, 15'h1234, 8'h00}, {1'b0, 15'h0042, 8'h00},
      {1'b1, 15'h0001, 8'hFF}, {1'b1, 15'h0002, 8'h00}, {1'b0, 15'h0001, 8'h00},
      {1'b0, 15'h0002, 8'h00}
   };

   initial begin
      int n;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      chk("R1", "ce_n in reset", sram_ce_n, 1);
      chk("R1", "oe_n in reset", sram_oe_n, 1);
      chk("R1", "we_n in reset", sram_we_n, 1);
      chk("R1", "dq_oe in reset", sram_dq_oe, 0);
      chk("R1", "ready in reset", req_ready, 1);
      chk("R1", "done in reset", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", req_ready, 1);
      chk("R1", "ce_n after reset", sram_ce_n, 1);

      for (int i = 0; i < NV; i++) run(VEC[i][23], VEC[i][22:8], VEC[i][7:0]);

      // R4/R5: setup phase shape of a write
      issue(1'b1, 15'h0300, 8'h6B);
      @(negedge clk);
      chk("R5", "setup strobe high", sram_we_n, 1);
      chk("R5", "setup drivers off", sram_dq_oe, 0);
      chk("R4", "setup oe_n high", sram_oe_n, 1);
      @(negedge clk);
      chk("R3", "strobe low in pulse", sram_we_n, 0);
      chk("R4", "drivers on in pulse", sram_dq_oe, 1);
      repeat (E_WP) @(negedge clk);
      chk("R5", "recovery strobe high", sram_we_n, 1);
      chk("R5", "recovery select high", sram_ce_n, 1);
      chk("R5", "recovery data held", sram_dq_oe, 1);
      @(negedge clk);
      chk("R7", "write done", done, 1);
      refm[32'h300] = 8'h6B;
      run(1'b0, 15'h0300, 8'h00);

      // R8/R6: a write waits while a read finishes
      issue(1'b0, 15'h7FFF, 8'h00);
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (n == 2) begin
            req_write = 1'b1; req_addr = 15'h0100; req_wdata = 8'h77; req_valid = 1'b1;
         end
         if (!done) begin
            chk("R6", "read address held", sram_addr, 15'h7FFF);
            chk("R6", "ready low while queued", req_ready, 0);
         end
      end while (!done && n < 40);
      chk("R7", "read latency with queued write", n, L_RD + 1);
      chk("R2", "read data with queued write", rd_data, ref_get(15'h7FFF));
      chk("R8", "select high between accesses", sram_ce_n, 1);
      chk("R8", "ready in done cycle", req_ready, 1);
      @(posedge clk);
      #1;
      req_valid = 1'b0; req_addr = 15'h0555; req_wdata = 8'h11;
      wait_done(n);
      chk("R8", "queued write latency", n, L_WR + 1);
      refm[32'h100] = 8'h77;
      run(1'b0, 15'h0100, 8'h00);

      // R1: reset during write setup leaves memory untouched
      issue(1'b1, 15'h0200, 8'h99);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "ce_n after abort", sram_ce_n, 1);
      chk("R1", "we_n after abort", sram_we_n, 1);
      chk("R1", "ready after abort", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      run(1'b0, 15'h0200, 8'h00);
      chk("R1", "aborted write absent", rd_data, 8'h00);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule